// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a single down-counting timer that a processor controls through a small word-addressed register bus. Software writes a start value, picks how the counter behaves when it reaches zero, and selects how often the counter steps. The counter steps on every clock, on every 16th clock or on every 256th clock. When the count steps down onto zero, the block sets an internal event flag. If interrupts are enabled, the flag drives the interrupt line until software writes the clear register.

When the count is zero and the counter steps again, one of three things happens. It can wrap to the all-ones value of the selected width (free-running). It can reload from the stored start value (periodic). It can stay at zero (one-shot). The counter can run at the full 32 bits or at 16 bits. At 16 bits only the low half counts, and the upper half keeps its value.

Top module: `pdt_timer`

## Requirements
- R1: After a synchronous reset, the start-value register reads 0, the count reads 0xFFFF_FFFF, the control register reads 0 and `irq` is low.
- R2: A write to offset 0x0 stores the start value and also sets the count to that value at the same clock edge. This write takes priority over a counter step in that cycle and restarts the prescale phase.
- R3: A write to the count register at offset 0x4 changes nothing: the count keeps following its own rules.
- R4: When control bit 7 (run) is 0, the count holds its value.
- R5: Control bits 3:2 select the step rate. Code 00 steps every clock, 01 every 16 clocks, and 10 or 11 every 256 clocks. The first step comes that many clocks after run is set.
- R6: With control bit 6 at 0 (free-running), a step taken at zero loads all ones into the active width.
- R7: With control bit 6 at 1 (periodic), a step taken at zero copies the active width of the stored start value into the count.
- R8: With control bit 0 at 1 (one-shot), a step taken at zero leaves the count at zero. This overrides R6 and R7.
- R9: Control bit 1 selects the width: 0 is 16 bits, 1 is 32 bits. At 16 bits, bits 31:16 of the count never change except through an R2 load.
- R10: A step from 1 to 0 in the active width sets an event flag. Any write to offset 0xC clears the flag, but a set in the same cycle wins. `irq` shows the flag ANDed with control bit 5, one clock after the flag and bit 5 take their values.
- R11: All eight control bits read back exactly as written, including the spare bit 4, so software can do read-modify-write.
- R12: Read data appears on `bus_rdata` the clock after `bus_rd` and holds until the next read. Reads of offset 0xC, of a misaligned address or of an unmapped address return 0, and writes to them (other than 0xC) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A behavioural model of the bench runs beside the timer, and the two are compared on every clock under several patterns.

- **Step rates:** the counter runs at each of the four step-rate codes. Codes 10 and 11 are tried separately to show whether the spare code acts the same as the slow rate.
- **Zero behaviour:** free-running, periodic and one-shot runs from small start values show which zero action the logic takes.
- **16-bit width:** a 16-bit run from a start value with a nonzero upper half shows whether the upper bits leak into the count.
- **Flag clearing:** a burst of clear writes during a short periodic run makes a clear and a set land in the same cycle, which exercises the ordering rule for the flag.

// File: rtl/pdt_pkg.sv
`timescale 1ns/1ps
package pdt_pkg;

  // Word select taken from address bits 3:2
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } pdt_sel_e;

  // Control byte, most significant field first (bit 7 .. bit 0)
  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       irq_en;    // bit 5
    logic       spare;     // bit 4, stored and read back only
    logic [1:0] rate;      // bits 3:2
    logic       wide;      // bit 1
    logic       single;    // bit 0
  } pdt_ctrl_t;

  localparam int CTRL_W = $bits(pdt_ctrl_t);

endpackage

// File: rtl/pdt_regs.sv
`timescale 1ns/1ps
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_val,
  output pdt_ctrl_t         ctrl,
  output logic [DATA_W-1:0] start_val,
  output logic              start_we,
  output logic              clear_we,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - CTRL_W;

  logic      hit;
  pdt_sel_e  sel;
  pdt_ctrl_t ctrl_q;
  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] rdata_q;

  // Only word-aligned addresses inside the four-word window decode
  assign hit = ((addr >> 4) == '0) && (addr[1:0] == 2'b00);
  assign sel = pdt_sel_e'(addr[3:2]);

  assign start_we = wr_en && hit && (sel == SEL_START);
  assign clear_we = wr_en && hit && (sel == SEL_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      start_q <= '0;
    end else begin
      if (wr_en && hit && (sel == SEL_CTRL)) ctrl_q <= pdt_ctrl_t'(wdata[CTRL_W-1:0]);
      if (start_we) start_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (!hit) begin
        rdata_q <= '0;
      end else begin
        unique case (sel)
          SEL_START: rdata_q <= start_q;
          SEL_COUNT: rdata_q <= count_val;
          SEL_CTRL:  rdata_q <= {{PAD_W{1'b0}}, ctrl_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign ctrl      = ctrl_q;
  assign start_val = start_q;
  assign rdata     = rdata_q;

  // The control byte only moves on a decoded control write
  AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit && (sel == SEL_CTRL)) |=> $stable(ctrl_q)) else $error("ctrl changed"); // R11

endmodule

// File: rtl/pdt_prescaler.sv
`timescale 1ns/1ps
module pdt_prescaler #(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       tick
);

  localparam int CNT_W = HI_LOG2;
  localparam logic [CNT_W-1:0] MID_LIMIT = CNT_W'((1 << MID_LOG2) - 1);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] limit;

  // Rate codes 10 and 11 both take the slowest division
  always_comb begin
    unique case (rate)
      2'b00:   limit = '0;
      2'b01:   limit = MID_LIMIT;
      default: limit = '1;
    endcase
  end

  // ">=" keeps the phase bounded if the rate drops in mid-count
  assign tick = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) phase_q <= '0;
    else                                phase_q <= phase_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && (rate != 2'b00) && !restart) |=> (!tick || (rate == 2'b00))) else $error("ticks too close"); // R5

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick) else $error("tick while stopped"); // R4

endmodule

// File: rtl/pdt_counter.sv
`timescale 1ns/1ps
module pdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_data,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              periodic,
  input  logic              single,
  input  logic              wide,
  output logic [DATA_W-1:0] count,
  output logic              hit_zero
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [DATA_W-1:0] count_q, count_d, mask, active;
  logic at_zero;

  assign mask    = wide ? '1 : HALF_MASK;
  assign active  = count_q & mask;
  assign at_zero = (active == '0);

  always_comb begin
    count_d  = count_q;
    hit_zero = 1'b0;
    if (start_we) begin
      count_d = start_data;
    end else if (tick) begin
      if (at_zero) begin
        if (single)        count_d = count_q;
        else if (periodic) count_d = (count_q & ~mask) | (reload_val & mask);
        else               count_d = count_q | mask;
      end else begin
        // Active part is nonzero, so no borrow crosses into the upper half
        count_d  = count_q - 1'b1;
        hit_zero = (active == DATA_W'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '1;
    else     count_q <= count_d;
  end

  assign count = count_q;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_we) |=> $stable(count_q)) else $error("count moved while stopped"); // R4

  AST_SINGLE_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (single && at_zero && !start_we) |=> (count_q == $past(count_q))) else $error("one-shot left zero"); // R8

  AST_UPPER_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!wide && !start_we) |=> (count_q[DATA_W-1:HALF_W] == $past(count_q[DATA_W-1:HALF_W]))) else $error("upper half moved"); // R9

endmodule

// File: rtl/pdt_timer.sv
`timescale 1ns/1ps
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  pdt_ctrl_t         ctrl;
  logic [DATA_W-1:0] start_val, count_val;
  logic              start_we, clear_we, tick, hit_zero;
  logic              flag_q, irq_q;

  pdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .count_val (count_val),
    .ctrl      (ctrl),
    .start_val (start_val),
    .start_we  (start_we),
    .clear_we  (clear_we),
    .rdata     (bus_rdata)
  );

  pdt_prescaler #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) pre_i (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl.run),
    .restart (start_we),
    .rate    (ctrl.rate),
    .tick    (tick)
  );

  pdt_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl.run),
    .tick       (tick),
    .start_we   (start_we),
    .start_data (bus_wdata),
    .reload_val (start_val),
    .periodic   (ctrl.periodic),
    .single     (ctrl.single),
    .wide       (ctrl.wide),
    .count      (count_val),
    .hit_zero   (hit_zero)
  );

  // Event flag: a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (hit_zero) flag_q <= 1'b1;
    else if (clear_we) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q & ctrl.irq_en;
  end

  assign irq = irq_q;

  AST_COUNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADDR_W'(4))) |-> !start_we) else $error("count write decoded"); // R3

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (clear_we && !hit_zero) |=> !flag_q) else $error("flag survived clear"); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    hit_zero |=> flag_q) else $error("flag not set"); // R10

endmodule

// File: tb/pdt_timer_tb.sv
`timescale 1ns/1ps
module pdt_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model state
  logic [31:0] m_start, m_cnt, m_rdata;
  logic [7:0]  m_ctrl;
  bit          m_flag, m_irq;
  int          m_pre;
  logic [31:0] m_mask, m_active, m_next;
  int          m_div;
  bit          m_ld, m_tk, m_hit;

  always #2.5 clk = ~clk; // 200 MHz

  pdt_timer dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_start = '0; m_cnt = 32'hFFFF_FFFF; m_ctrl = '0;
      m_flag = 0; m_irq = 0; m_pre = 0; m_rdata = '0;
    end else begin
      m_mask = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      case (m_ctrl[3:2])
        2'b00:   m_div = 1;
        2'b01:   m_div = 16;
        default: m_div = 256;
      endcase
      m_ld = bus_wr && (bus_addr == 4'h0);
      m_tk = m_ctrl[7] && (m_pre >= m_div - 1);
      m_active = m_cnt & m_mask;
      m_hit = 0;
      m_next = m_cnt;
      if (m_ld) m_next = bus_wdata;
      else if (m_tk) begin
        if (m_active == 0) begin
          if (m_ctrl[0]) m_next = m_cnt;
          else if (m_ctrl[6]) m_next = (m_cnt & ~m_mask) | (m_start & m_mask);
          else m_next = m_cnt | m_mask;
        end else begin
          m_next = m_cnt - 1;
          m_hit = (m_active == 1);
        end
      end
      if (bus_rd) begin
        if (bus_addr == 4'h0)      m_rdata = m_start;
        else if (bus_addr == 4'h4) m_rdata = m_cnt;
        else if (bus_addr == 4'h8) m_rdata = {24'h0, m_ctrl};
        else                       m_rdata = '0;
      end
      m_irq = m_flag && m_ctrl[5];
      if (m_hit) m_flag = 1;
      else if (bus_wr && bus_addr == 4'hC) m_flag = 0;
      if (!m_ctrl[7] || m_ld || m_tk) m_pre = 0; else m_pre++;
      if (bus_wr && bus_addr == 4'h8) m_ctrl = bus_wdata[7:0];
      if (m_ld) m_start = bus_wdata;
      m_cnt = m_next;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "per-cycle rdata", bus_rdata, m_rdata);
      chk(cur_req, "per-cycle irq", {31'h0, irq}, {31'h0, m_irq});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input logic [31:0] msk, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, "read", bus_rdata & msk, exp & msk);
  endtask

  task automatic rd_model(input logic [3:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL watchdog all actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
    rd_expect(4'h0, 32'h0, '1, "R1");
    rd_expect(4'h4, 32'hFFFF_FFFF, '1, "R1");
    rd_expect(4'h8, 32'h0, '1, "R1");
    // R2 start write loads the count at once
    cur_req = "R2";
    wr(4'h0, 32'h1234_5678);
    rd_expect(4'h4, 32'h1234_5678, '1, "R2");
    rd_expect(4'h0, 32'h1234_5678, '1, "R2");
    // R3 count register is read-only
    cur_req = "R3";
    wr(4'h4, 32'h0000_DEAD);
    rd_expect(4'h4, 32'h1234_5678, '1, "R3");
    // R11 all control bits read back, spare included
    cur_req = "R11";
    wr(4'h8, 32'h0000_0010);
    rd_expect(4'h8, 32'h10, '1, "R11");
    wr(4'h8, 32'h0000_007D);
    rd_expect(4'h8, 32'h7D, '1, "R11");
    wr(4'h8, 32'h0);
    // R12 clear offset, misaligned and unmapped reads give 0
    cur_req = "R12";
    rd_expect(4'hC, 32'h0, '1, "R12");
    rd_expect(4'h3, 32'h0, '1, "R12");
    wr(4'h9, 32'h0000_00FF);
    rd_expect(4'h8, 32'h0, '1, "R12");
    // R6 free-running 32-bit wrap
    cur_req = "R6";
    wr(4'h0, 32'd3);
    wr(4'h8, 32'h82);
    idle(8);
    wr(4'h8, 32'h02);
    rd_model(4'h4);
    // R4 stopped count holds
    cur_req = "R4";
    idle(10);
    rd_model(4'h4);
    rd_model(4'h4);
    // R7 periodic reload
    cur_req = "R7";
    wr(4'h0, 32'd5);
    wr(4'h8, 32'hC2);
    for (int i = 0; i < 20; i++) rd_model(4'h4);
    wr(4'h8, 32'h0);
    // R8 one-shot stops at zero
    cur_req = "R8";
    wr(4'h0, 32'd4);
    wr(4'h8, 32'h83);
    idle(10);
    rd_expect(4'h4, 32'h0, '1, "R8");
    idle(5);
    rd_expect(4'h4, 32'h0, '1, "R8");
    wr(4'h8, 32'h0);
    // R9 16-bit width keeps the upper half
    cur_req = "R9";
    wr(4'h0, 32'hABCD_0002);
    wr(4'h8, 32'h80);
    idle(6);
    wr(4'h8, 32'h00);
    rd_expect(4'h4, 32'hABCD_0000, 32'hFFFF_0000, "R9");
    rd_model(4'h4);
    wr(4'h0, 32'hABCD_0003);
    wr(4'h8, 32'hC0);
    idle(12);
    wr(4'h8, 32'h00);
    rd_expect(4'h4, 32'hABCD_0000, 32'hFFFF_0000, "R9");
    // R5 step rates 01, 10 and 11
    cur_req = "R5";
    wr(4'h0, 32'd100);
    wr(4'h8, 32'h86);
    for (int i = 0; i < 20; i++) begin idle(3); rd_model(4'h4); end
    wr(4'h8, 32'h8A);
    for (int i = 0; i < 60; i++) begin idle(9); rd_model(4'h4); end
    wr(4'h8, 32'h8E);
    for (int i = 0; i < 60; i++) begin idle(9); rd_model(4'h4); end
    wr(4'h8, 32'h0);
    // R10 event flag, interrupt enable and clear ordering
    cur_req = "R10";
    wr(4'h0, 32'd3);
    wr(4'h8, 32'hE2);
    idle(8);
    wr(4'hC, 32'h0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = '0;
    end
    @(negedge clk) bus_wr = 1'b0;
    wr(4'h8, 32'h02);
    idle(3);
    wr(4'h8, 32'h22);
    idle(3);
    wr(4'hC, 32'h0);
    idle(4);
    chk("R10", "irq after clear", {31'h0, irq}, 32'h0);
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule